// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block turns a stream of stereo sample pairs into a one-wire serial audio stream. It has a frame clock that marks left and right halves of each frame, and a bit clock whose falling edge moves the data line to the next bit. A 2-bit mode input chooses who owns the clocks and which framing is used. In the master modes the block divides its own master clock to make the bit and frame clocks. In the slave modes it follows external clocks, which it brings into the master-clock domain before it finds their edges.

Framing is either left-justified or I2S. The two differ in two ways: the level of the frame clock that marks the left half, and whether the most significant bit follows the frame edge at once or one bit clock later. A speed input picks the master-clock divider, so the bit clock runs at 64 times the frame rate whether the master clock is 256 or 128 times the sample rate. A new sample pair is offered on a one-cycle valid strobe and is held until the next left half begins. If no new pair arrives, the last pair is sent again.

Top module: `audio_serial_tx`

## Requirements
- R1: modeSel bit 0 selects clock ownership (1 = master, 0 = slave) and bit 1 selects framing (1 = I2S, 0 = left-justified), so 00 is slave, 01 is master, 10 is I2S slave and 11 is I2S master. In slave modes bclkOut never toggles.
- R2: In left-justified framing the frame clock is high for the left half and low for the right half.
- R3: In I2S framing the frame clock is low for the left half and high for the right half.
- R4: Each half carries a 24-bit two's-complement word, most significant bit first. In left-justified framing the MSB occupies the first bit slot after the frame-clock edge.
- R5: In I2S framing the MSB occupies the second bit slot after the frame-clock edge, and the first slot carries 0.
- R6: Each half has 32 bit slots. Every slot outside the word's 24 slots drives 0.
- R7: In master mode at normal speed (dblSpeed = 0), bclkOut has a period of 4 master-clock cycles, low for the first half and high for the second. Data and frame clock change only where bclkOut falls, and a frame lasts 64 bit clocks.
- R8: In master mode at double speed (dblSpeed = 1), bclkOut has a period of 2 master-clock cycles and stays high for one cycle.
- R9: In slave modes bclkOut and lrclkOut stay low. The data line changes within 3 master-clock cycles after a falling edge of bclkIn, and the bit position is re-anchored at every lrclkIn edge.
- R10: A pair presented with sampleValid high is sent starting at the next left-half edge. Until a newer pair is accepted, every later frame repeats that pair.
- R11: While rstN is low, sdata and bclkOut are 0. lrclkOut shows the right-half level in master modes and 0 in slave modes. The held sample pair resets to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | Bit 0 = master clocking, bit 1 = I2S framing |
| dblSpeed | input | 1 | 1 = master clock at 128x frame rate, 0 = 256x |
| sampleValid | input | 1 | One-cycle strobe accepting leftSample/rightSample |
| leftSample | input | 24 | Left word, two's complement |
| rightSample | input | 24 | Right word, two's complement |
| bclkIn | input | 1 | External bit clock, used in slave modes |
| lrclkIn | input | 1 | External frame clock, used in slave modes |
| sdata | output | 1 | Serial data |
| bclkOut | output | 1 | Generated bit clock, master modes |
| lrclkOut | output | 1 | Generated frame clock, master modes |

## Verification
The bench builds the block with its default parameters: 24-bit words, 32-slot halves, dividers of 4 and 2, and two synchronizer stages. With these values a master frame is 256 or 128 master-clock cycles, so all four modes and both speeds fit in one short run. The bench drives slave clocks at one bit clock per 8 master-clock cycles. This keeps the three-cycle synchronizer latency inside one low half of the bit clock, so a receiver model that samples on the rising edge sees whether data changed where it should. The directed pairs (full-scale positive and negative, all ones, one LSB, zero) and random pairs expose any error in bit order, bit delay or polarity as a word mismatch.

// File: rtl/ast_pkg.sv
package ast_pkg;

  // Strobes from control to datapath, valid for one master-clock cycle
  typedef struct packed {
    logic bitStep;     // advance serializer by one bit slot
    logic leftStart;   // this step opens the left half
    logic rightStart;  // this step opens the right half
  } txStrobe_t;

endpackage

// File: rtl/ast_sync.sv
module ast_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pipe <= '0;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) begin
        pipe[i] <= pipe[i-1];
      end
    end
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/ast_ctrl.sv
module ast_ctrl
  import ast_pkg::*;
#(
  parameter int SLOT_W      = 32,
  parameter int DIV_NORMAL  = 4,
  parameter int DIV_DOUBLE  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      isMaster,
  input  logic      isI2s,
  input  logic      dblSpeed,
  input  logic      bclkIn,
  input  logic      lrclkIn,
  output txStrobe_t strobe,
  output logic      bclkOut,
  output logic      lrclkOut
);

  localparam int FRAME_BITS = 2 * SLOT_W;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int DIV_MAX    = (DIV_NORMAL > DIV_DOUBLE) ? DIV_NORMAL : DIV_DOUBLE;
  localparam int DIV_W      = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;
  localparam logic [POS_W-1:0] POS_MAX   = '1;
  localparam logic [POS_W-1:0] POS_RIGHT = POS_W'(SLOT_W);

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLimit;
  logic [DIV_W-1:0] divHalf;
  logic [POS_W-1:0] posQ;
  logic [POS_W-1:0] nextPos;
  logic [1:0]       syncOut;
  logic             bSync;
  logic             lSync;
  logic             bPrev;
  logic             lLast;
  logic             masterStep;
  logic             slaveStep;
  logic             leftLevel;

  // Speed select picks the divider so both speeds give 64 bit clocks per frame
  assign divLimit = dblSpeed ? DIV_W'(DIV_DOUBLE - 1) : DIV_W'(DIV_NORMAL - 1);
  assign divHalf  = dblSpeed ? DIV_W'(DIV_DOUBLE / 2) : DIV_W'(DIV_NORMAL / 2);

  always_ff @(posedge clk) begin
    if (!rstN || !isMaster) begin
      divCnt <= '0;
    end else if (divCnt == divLimit) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // External clocks into the master-clock domain
  ast_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({bclkIn, lrclkIn}),
    .dout (syncOut)
  );
  assign bSync = syncOut[1];
  assign lSync = syncOut[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bPrev <= 1'b0;
      lLast <= 1'b0;
    end else begin
      bPrev <= bSync;
      if (slaveStep) lLast <= lSync;
    end
  end

  assign leftLevel  = !isI2s;
  assign masterStep = isMaster && (divCnt == divLimit);
  assign slaveStep  = !isMaster && bPrev && !bSync;

  always_comb begin
    strobe  = '0;
    nextPos = posQ;
    if (masterStep) begin
      nextPos           = posQ + 1'b1;
      strobe.bitStep    = 1'b1;
      strobe.leftStart  = (nextPos == '0);
      strobe.rightStart = (nextPos == POS_RIGHT);
    end else if (slaveStep) begin
      strobe.bitStep = 1'b1;
      if (lSync != lLast) begin
        if (lSync == leftLevel) begin
          nextPos          = '0;
          strobe.leftStart = 1'b1;
        end else begin
          nextPos           = POS_RIGHT;
          strobe.rightStart = 1'b1;
        end
      end else if (posQ != POS_MAX) begin
        nextPos = posQ + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posQ <= POS_MAX;
    end else if (strobe.bitStep) begin
      posQ <= nextPos;
    end
  end

  assign bclkOut  = isMaster && (divCnt >= divHalf);
  assign lrclkOut = isMaster && (posQ[POS_W-1] ? !leftLevel : leftLevel);

  // R7: normal-speed bit clock stays high for two cycles
  p_half_period_r7: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && !dblSpeed && $rose(bclkOut)) |=> bclkOut ##1 !bclkOut);

  // R8: double-speed bit clock stays high for one cycle
  p_half_period_r8: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && dblSpeed && $rose(bclkOut)) |=> !bclkOut);

  // R2 / R3: frame clock moves only with a falling bit clock
  p_lr_on_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && !$stable(lrclkOut)) |-> $fell(bclkOut));

endmodule

// File: rtl/ast_datapath.sv
module ast_datapath
  import ast_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                isI2s,
  input  txStrobe_t           strobe,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  output logic                sdata
);

  localparam int SLOT_IDX_W = $clog2(SLOT_W);
  localparam logic [SLOT_IDX_W-1:0] SLOT_LAST = SLOT_IDX_W'(SLOT_W - 1);
  localparam logic [SLOT_IDX_W-1:0] WORD_END  = SLOT_IDX_W'(SAMPLE_W);

  logic [SAMPLE_W-1:0]   pendL, pendR, actL, actR;
  logic [SAMPLE_W-1:0]   word;
  logic [SAMPLE_W-1:0]   shifted;
  logic [SLOT_IDX_W-1:0] slotQ, nxtSlot, delay, kIdx;
  logic                  rightQ, nxtRight, inWindow, bitOut;

  always_comb begin
    if (strobe.leftStart) begin
      nxtSlot  = '0;
      nxtRight = 1'b0;
      word     = pendL;      // new pair goes out from the first left slot
    end else if (strobe.rightStart) begin
      nxtSlot  = '0;
      nxtRight = 1'b1;
      word     = actR;
    end else begin
      nxtSlot  = (slotQ == SLOT_LAST) ? slotQ : slotQ + 1'b1;
      nxtRight = rightQ;
      word     = rightQ ? actR : actL;
    end
    delay    = SLOT_IDX_W'(isI2s);
    kIdx     = nxtSlot - delay;
    inWindow = (nxtSlot >= delay) && (int'(kIdx) < SAMPLE_W);
    shifted  = word << kIdx;
    bitOut   = inWindow && shifted[SAMPLE_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendL  <= '0;
      pendR  <= '0;
      actL   <= '0;
      actR   <= '0;
      slotQ  <= SLOT_LAST;
      rightQ <= 1'b1;
      sdata  <= 1'b0;
    end else begin
      if (sampleValid) begin
        pendL <= leftIn;
        pendR <= rightIn;
      end
      if (strobe.bitStep) begin
        slotQ  <= nxtSlot;
        rightQ <= nxtRight;
        sdata  <= bitOut;
        if (strobe.leftStart) begin
          actL <= pendL;
          actR <= pendR;
        end
      end
    end
  end

  // R4: left-justified left half begins with the held word's MSB
  p_msb_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.bitStep && strobe.leftStart && !isI2s) |=> (sdata == $past(pendL[SAMPLE_W-1])));

  // R5: I2S leaves the first slot of each half at zero
  p_i2s_lead_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.bitStep && (strobe.leftStart || strobe.rightStart) && isI2s) |=> !sdata);

  // R6: slots past the word stay at zero
  p_pad_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.bitStep && !strobe.leftStart && !strobe.rightStart && (slotQ >= WORD_END)) |=> !sdata);

endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
  import ast_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int SLOT_W      = 32,
  parameter int DIV_NORMAL  = 4,
  parameter int DIV_DOUBLE  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          modeSel,
  input  logic                dblSpeed,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] leftSample,
  input  logic [SAMPLE_W-1:0] rightSample,
  input  logic                bclkIn,
  input  logic                lrclkIn,
  output logic                sdata,
  output logic                bclkOut,
  output logic                lrclkOut
);

  txStrobe_t strobe;
  logic      isMaster;
  logic      isI2s;

  assign isMaster = modeSel[0];
  assign isI2s    = modeSel[1];

  ast_ctrl #(
    .SLOT_W      (SLOT_W),
    .DIV_NORMAL  (DIV_NORMAL),
    .DIV_DOUBLE  (DIV_DOUBLE),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .isMaster (isMaster),
    .isI2s    (isI2s),
    .dblSpeed (dblSpeed),
    .bclkIn   (bclkIn),
    .lrclkIn  (lrclkIn),
    .strobe   (strobe),
    .bclkOut  (bclkOut),
    .lrclkOut (lrclkOut)
  );

  ast_datapath #(
    .SAMPLE_W (SAMPLE_W),
    .SLOT_W   (SLOT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .isI2s       (isI2s),
    .strobe      (strobe),
    .sampleValid (sampleValid),
    .leftIn      (leftSample),
    .rightIn     (rightSample),
    .sdata       (sdata)
  );

  // R7: in master modes the data line moves only on a falling bit clock
  p_sdata_on_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && !$stable(sdata)) |-> $fell(bclkOut));

endmodule

// File: tb/tb_audio_serial_tx.sv
module tb_audio_serial_tx;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  modeSel;
  logic        dblSpeed;
  logic        sampleValid;
  logic [23:0] leftSample, rightSample;
  logic        bclkIn, lrclkIn;
  logic        sdata, bclkOut, lrclkOut;

  always #4 clk = ~clk;

  audio_serial_tx dut (
    .clk (clk), .rstN (rstN), .modeSel (modeSel), .dblSpeed (dblSpeed),
    .sampleValid (sampleValid), .leftSample (leftSample), .rightSample (rightSample),
    .bclkIn (bclkIn), .lrclkIn (lrclkIn),
    .sdata (sdata), .bclkOut (bclkOut), .lrclkOut (lrclkOut)
  );

  int checks = 0;
  int failures = 0;
  int rightStarts = 0;
  int bclkOutEdges = 0;
  logic [23:0] expNextL, expNextR, expCurL, expCurR;

  // receiver model state
  bit          haveSync;
  logic        prevLr, prevB, prevBo;
  int          slotCnt, frameBits, perCnt;
  logic [31:0] shiftBuf;

  function automatic logic leftLvl(input logic [1:0] m);
    return !m[1];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finishChannel(input bit isRight);
    logic [23:0] got, want;
    logic [7:0]  pad;
    got  = modeSel[1] ? shiftBuf[30:7] : shiftBuf[31:8];
    pad  = modeSel[1] ? {shiftBuf[31], shiftBuf[6:0]} : shiftBuf[7:0];
    want = isRight ? expCurR : expCurL;
    check(slotCnt == 32, "R6", "slots per half", slotCnt, 32);
    check(pad == 8'h00, "R6", "padding slots", {24'h0, pad}, 0);
    if (modeSel[1])
      check(got == want, "R5 R3 R10", isRight ? "right word" : "left word", {8'h0, got}, {8'h0, want});
    else
      check(got == want, "R4 R2 R10", isRight ? "right word" : "left word", {8'h0, got}, {8'h0, want});
  endtask

  // Receiver: samples data and frame clock on each rising bit clock
  always @(negedge clk) begin
    logic bObs, lObs;
    if (!rstN) begin
      haveSync  = 1'b0;
      prevLr    = !leftLvl(modeSel);
      prevB     = 1'b0;
      prevBo    = 1'b0;
      slotCnt   = 0;
      frameBits = 0;
      perCnt    = 0;
      shiftBuf  = '0;
    end else begin
      if (bclkOut != prevBo) bclkOutEdges++;
      prevBo = bclkOut;
      bObs = modeSel[0] ? bclkOut  : bclkIn;
      lObs = modeSel[0] ? lrclkOut : lrclkIn;
      perCnt++;
      if (bObs && !prevB) begin
        if (modeSel[0] && haveSync)
          check(perCnt == (dblSpeed ? 2 : 4), dblSpeed ? "R8" : "R7", "bit clock period",
                perCnt, dblSpeed ? 2 : 4);
        perCnt = 0;
        if (!modeSel[0])
          check(!bclkOut && !lrclkOut, "R9", "slave clock outputs quiet",
                {30'h0, bclkOut, lrclkOut}, 0);
        if (lObs != prevLr) begin
          if (haveSync) finishChannel(prevLr != leftLvl(modeSel));
          if (lObs == leftLvl(modeSel)) begin
            if (haveSync && modeSel[0])
              check(frameBits == 64, "R7", "bit clocks per frame", frameBits, 64);
            haveSync  = 1'b1;
            frameBits = 0;
            expCurL   = expNextL;
            expCurR   = expNextR;
          end else begin
            rightStarts++;
          end
          slotCnt  = 0;
          shiftBuf = '0;
        end
        shiftBuf = {shiftBuf[30:0], sdata};
        slotCnt++;
        frameBits++;
        prevLr = lObs;
      end
      prevB = bObs;
    end
  end

  task automatic waitRight(input int n);
    int snap;
    for (int i = 0; i < n; i++) begin
      snap = rightStarts;
      wait (rightStarts != snap);
    end
  endtask

  task automatic sendPair(input logic [23:0] l, input logic [23:0] r);
    waitRight(1);
    @(negedge clk);
    sampleValid = 1'b1;
    leftSample  = l;
    rightSample = r;
    @(negedge clk);
    sampleValid = 1'b0;
    leftSample  = $urandom();
    rightSample = $urandom();
    expNextL = l;
    expNextR = r;
  endtask

  task automatic stimulus(input int n);
    for (int i = 0; i < n; i++) begin
      case (i)
        0: sendPair(24'h7FFFFF, 24'h800000);
        1: sendPair(24'hFFFFFF, 24'h000001);
        2: sendPair(24'h000000, 24'hA5A5A5);
        default: sendPair(24'($urandom()), 24'($urandom()));
      endcase
    end
    waitRight(1);  // R10: no new pair, last one must repeat
  endtask

  task automatic slaveGen(input int frames, input logic i2s);
    logic lft;
    lft = !i2s;
    for (int b = 0; b < 4 + frames * 64 + 1; b++) begin
      @(posedge clk); #1;
      bclkIn = 1'b0;
      if (b < 4) lrclkIn = !lft;
      else lrclkIn = (((b - 4) % 64) < 32) ? lft : !lft;
      repeat (4) @(posedge clk);
      #1;
      bclkIn = 1'b1;
      repeat (3) @(posedge clk);
    end
  endtask

  task automatic runCfg(input logic [1:0] m, input logic dbl, input int nPairs);
    rstN = 1'b0; modeSel = m; dblSpeed = dbl; sampleValid = 1'b0;
    bclkIn = 1'b1; lrclkIn = m[1];
    expNextL = '0; expNextR = '0;
    repeat (3) @(negedge clk);
    check(sdata == 1'b0 && bclkOut == 1'b0, "R11", "reset data and bit clock",
          {30'h0, sdata, bclkOut}, 0);
    check(lrclkOut == (m[0] ? m[1] : 1'b0), "R11", "reset frame clock",
          {31'h0, lrclkOut}, {31'h0, (m[0] ? m[1] : 1'b0)});
    bclkOutEdges = 0;
    rstN = 1'b1;
    if (!m[0]) begin
      fork
        slaveGen(nPairs + 4, m[1]);
        stimulus(nPairs);
      join
    end else begin
      stimulus(nPairs);
      waitRight(2);
    end
    check((bclkOutEdges > 0) == m[0], "R1", "bit clock activity by mode",
          {31'h0, (bclkOutEdges > 0)}, {31'h0, m[0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R7 watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    rstN = 1'b0; modeSel = 2'b01; dblSpeed = 1'b0; sampleValid = 1'b0;
    leftSample = '0; rightSample = '0; bclkIn = 1'b1; lrclkIn = 1'b0;
    runCfg(2'b01, 1'b0, 5);  // master, normal speed
    runCfg(2'b01, 1'b1, 5);  // master, double speed
    runCfg(2'b11, 1'b0, 5);  // I2S master, normal
    runCfg(2'b11, 1'b1, 5);  // I2S master, double
    runCfg(2'b00, 1'b0, 5);  // slave
    runCfg(2'b10, 1'b0, 5);  // I2S slave
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule